// File: doc/BRIEF.md
# Cache Range Maintenance Sequencer

This block accepts one cache maintenance command at a time: a byte range given by a start address and an exclusive end address, together with an operation (invalidate, clean, or flush). It turns that range into a series of line-granular requests on a downstream maintenance port. Each range request carries a chunk start address, an inclusive chunk end address (the address of the last line in the chunk), and an operation kind. The sequencer then waits for a one-cycle completion strobe before it issues the next request. Chunks are capped in byte size, because every downstream range operation stalls its requester. They also never cross a page, so a single translation of the chunk start is valid for the whole chunk.

For invalidate, a partial line at either edge of the range is not discarded. Each partial edge line is sent as a single-line clean-and-invalidate before the aligned body is invalidated. Clean and flush widen the range outward to whole lines. A write-through override input, captured when the command is accepted, suppresses every clean step. Under the override a clean command issues nothing, and a flush issues only invalidates. Every command, even one that issued nothing, finishes with a one-cycle barrier pulse.

Top module: `cache_range_seq`

## Requirements
- R1: After reset, cmdReady is 1, and busy, mOpValid and barrier are 0.
- R2: Each range request (kind 0 = invalidate range, kind 1 = clean range) covers at most MAX_CHUNK bytes. Its mOpEnd is the chunk boundary minus LINE_BYTES, so it is the first byte of the last line in the chunk. The chunk boundary is the smallest of three values: the range end, the chunk start plus MAX_CHUNK, and the next page boundary.
- R3: The mOpStart and mOpEnd of a range request always lie in the same PAGE_BYTES page.
- R4: For invalidate (cmdOp 0) with an unaligned start, the first request is kind 2 (single-line clean-and-invalidate) with mOpStart = mOpEnd = the start rounded down to a line boundary. The start then moves to the next line boundary.
- R5: For invalidate, after the start step, if the start is below the end and the end is unaligned, a kind-2 request is issued on the line that contains the end. The end is then rounded down to a line boundary before any range request is issued.
- R6: For clean (cmdOp 1) and flush (cmdOp 2), the start is rounded down and the end is rounded up to line boundaries before chunking. Chunks are issued in ascending address order. A cmdOp value of 3 behaves as clean.
- R7: When wtOverride is 1 at acceptance, a clean command issues no requests.
- R8: A flush issues, for each chunk, a clean-range request followed by an invalidate-range request over the same addresses. With wtOverride set it issues only the invalidate-range request. mOpValid and the request fields hold steady until mOpDone is seen.
- R9: Exactly one barrier pulse, one cycle long, follows the completion of the last request of every command. busy is 0 in the cycle after it.
- R10: While busy, cmdReady is 0, and changes on cmdValid, cmdOp, cmdStart, cmdEnd and wtOverride have no effect on the requests of the command in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Sequencer can accept a command |
| cmdOp | input | 2 | 0 invalidate, 1 clean, 2 flush, 3 treated as clean |
| cmdStart | input | ADDR_W | First byte of range |
| cmdEnd | input | ADDR_W | Byte after the range (exclusive) |
| wtOverride | input | 1 | Write-through override, skips clean steps |
| mOpValid | output | 1 | Downstream request valid |
| mOpKind | output | 2 | 0 invalidate range, 1 clean range, 2 clean-and-invalidate line |
| mOpStart | output | ADDR_W | Request start line address |
| mOpEnd | output | ADDR_W | Request inclusive end line address |
| mOpDone | input | 1 | Downstream request complete |
| busy | output | 1 | Command in progress |
| barrier | output | 1 | One-cycle completion pulse per command |

## Verification
The bench builds the block with ADDR_W = 10, LINE_BYTES = 32, MAX_CHUNK = 128 and PAGE_BYTES = 256. With these values a range of a few hundred bytes meets the size cap, page boundaries and both partial edges within one command. Start addresses and range lengths are swept on co-prime strides, so starts and ends fall on every alignment within a line and a page. Each of the three operations is run with the override both off and on, and the downstream completion latency varies. Empty ranges and ranges that lie inside a single line are part of the sweep, which covers the case where the invalidate head step passes the end.

// File: rtl/cache_range_seq_pkg.sv
package cache_range_seq_pkg;

  typedef enum logic [1:0] {
    OP_INV   = 2'd0,
    OP_CLEAN = 2'd1,
    OP_FLUSH = 2'd2
  } cmdOp_e;

  typedef enum logic [1:0] {
    KIND_INV_RANGE   = 2'd0,
    KIND_CLEAN_RANGE = 2'd1,
    KIND_CI_LINE     = 2'd2
  } opKind_e;

  typedef enum logic [1:0] {
    SEL_HEAD  = 2'd0,
    SEL_TAIL  = 2'd1,
    SEL_RANGE = 2'd2
  } addrSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;
    logic     headAdv;
    logic     tailTrim;
    logic     chunkAdv;
    addrSel_e sel;
  } ctrlStrb_t;

  // status from datapath to control
  typedef struct packed {
    logic startUnal;
    logic endUnal;
    logic haveWork;
  } dpFlags_t;

endpackage

// File: rtl/cache_range_seq_dp.sv
module cache_range_seq_dp
  import cache_range_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int MAX_CHUNK  = 1024,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdStart,
  input  logic [ADDR_W-1:0] cmdEnd,
  output dpFlags_t          flags,
  output logic [ADDR_W-1:0] mOpStart,
  output logic [ADDR_W-1:0] mOpEnd
);
  localparam int EW = ADDR_W + 1;
  localparam int LINE_SHIFT = $clog2(LINE_BYTES);
  localparam logic [EW-1:0] LMASK = EW'(LINE_BYTES - 1);
  localparam logic [EW-1:0] PMASK = EW'(PAGE_BYTES - 1);
  localparam logic [EW-1:0] CHUNK = EW'(MAX_CHUNK);
  localparam logic [EW-1:0] LINE  = EW'(LINE_BYTES);

  logic [EW-1:0] startR, endR;
  logic [EW-1:0] bySize, byPage, capLim, boundary;
  logic [EW-1:0] ldStart, ldEnd;

  // load-time alignment: only clean and flush widen to whole lines
  always_comb begin
    ldStart = {1'b0, cmdStart};
    ldEnd   = {1'b0, cmdEnd};
    if (cmdOp != OP_INV) begin
      ldStart = ldStart & ~LMASK;
      ldEnd   = (ldEnd + LMASK) & ~LMASK;
    end
  end

  // chunk boundary: min of range end, size cap and next page
  always_comb begin
    bySize   = startR + CHUNK;
    byPage   = (startR | PMASK) + 1'b1;
    capLim   = (bySize < byPage) ? bySize : byPage;
    boundary = (endR < capLim) ? endR : capLim;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startR <= '0;
      endR   <= '0;
    end else begin
      if (strb.load) begin
        startR <= ldStart;
        endR   <= ldEnd;
      end
      if (strb.headAdv)  startR <= (startR | LMASK) + 1'b1;
      if (strb.tailTrim) endR   <= endR & ~LMASK;
      if (strb.chunkAdv) startR <= boundary;
    end
  end

  assign flags.startUnal = |startR[LINE_SHIFT-1:0];
  assign flags.endUnal   = |endR[LINE_SHIFT-1:0];
  assign flags.haveWork  = startR < endR;

  logic [EW-1:0] selStart, selEnd;
  always_comb begin
    unique case (strb.sel)
      SEL_HEAD: begin
        selStart = startR & ~LMASK;
        selEnd   = startR & ~LMASK;
      end
      SEL_TAIL: begin
        selStart = endR & ~LMASK;
        selEnd   = endR & ~LMASK;
      end
      default: begin
        selStart = startR;
        selEnd   = boundary - LINE;
      end
    endcase
  end
  assign mOpStart = selStart[ADDR_W-1:0];
  assign mOpEnd   = selEnd[ADDR_W-1:0];

  // R2: an advance never moves the start backwards or past the end
  a_r2_advance_bounded: assert property (@(posedge clk) disable iff (!rstN)
    strb.chunkAdv |=> (startR > $past(startR)) && (startR <= endR));

endmodule

// File: rtl/cache_range_seq_ctrl.sv
module cache_range_seq_ctrl
  import cache_range_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       wtOverride,
  input  dpFlags_t   flags,
  input  logic       mOpDone,
  output ctrlStrb_t  strb,
  output logic       cmdReady,
  output logic       mOpValid,
  output logic [1:0] mOpKind,
  output logic       busy,
  output logic       barrier
);
  typedef enum logic [3:0] {
    S_IDLE, S_PREP, S_HEAD, S_TAILCHK, S_TAIL,
    S_LOOP, S_CLEAN, S_INV, S_DONE
  } state_e;

  state_e state, nextState;
  logic [1:0] opR;
  logic wtR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      opR   <= OP_INV;
      wtR   <= 1'b0;
    end else begin
      state <= nextState;
      if (strb.load) begin
        opR <= cmdOp;
        wtR <= wtOverride;
      end
    end
  end

  always_comb begin
    nextState = state;
    strb      = '{load: 1'b0, headAdv: 1'b0, tailTrim: 1'b0,
                  chunkAdv: 1'b0, sel: SEL_RANGE};
    mOpValid  = 1'b0;
    mOpKind   = KIND_INV_RANGE;
    unique case (state)
      S_IDLE: if (cmdValid) begin
        strb.load = 1'b1;
        nextState = S_PREP;
      end
      S_PREP:
        if (opR == OP_INV) nextState = flags.startUnal ? S_HEAD : S_TAILCHK;
        else               nextState = S_LOOP;
      S_HEAD: begin
        mOpValid = 1'b1;
        mOpKind  = KIND_CI_LINE;
        strb.sel = SEL_HEAD;
        if (mOpDone) begin
          strb.headAdv = 1'b1;
          nextState    = S_TAILCHK;
        end
      end
      S_TAILCHK:
        nextState = (flags.haveWork && flags.endUnal) ? S_TAIL : S_LOOP;
      S_TAIL: begin
        mOpValid = 1'b1;
        mOpKind  = KIND_CI_LINE;
        strb.sel = SEL_TAIL;
        if (mOpDone) begin
          strb.tailTrim = 1'b1;
          nextState     = S_LOOP;
        end
      end
      S_LOOP:
        if (!flags.haveWork)   nextState = S_DONE;
        else if (opR == OP_INV) nextState = S_INV;
        else if (opR == OP_FLUSH) nextState = wtR ? S_INV : S_CLEAN;
        else                    nextState = wtR ? S_DONE : S_CLEAN;
      S_CLEAN: begin
        mOpValid = 1'b1;
        mOpKind  = KIND_CLEAN_RANGE;
        if (mOpDone) begin
          if (opR == OP_FLUSH) nextState = S_INV;
          else begin
            strb.chunkAdv = 1'b1;
            nextState     = S_LOOP;
          end
        end
      end
      S_INV: begin
        mOpValid = 1'b1;
        mOpKind  = KIND_INV_RANGE;
        if (mOpDone) begin
          strb.chunkAdv = 1'b1;
          nextState     = S_LOOP;
        end
      end
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign cmdReady = (state == S_IDLE);
  assign busy     = (state != S_IDLE);
  assign barrier  = (state == S_DONE);

  // R10: a command only starts from an accepted handshake
  a_r10_start_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdValid) && $past(cmdReady));

  // R9: barrier is a single-cycle pulse that ends the command
  a_r9_barrier_pulse: assert property (@(posedge clk) disable iff (!rstN)
    barrier |=> !barrier && !busy);

  // R8: a flush invalidate follows its clean on the same chunk
  a_r8_flush_order: assert property (@(posedge clk) disable iff (!rstN)
    (mOpValid && mOpKind == KIND_CLEAN_RANGE && mOpDone && opR == OP_FLUSH)
      |=> mOpValid && mOpKind == KIND_INV_RANGE);

  // R7: override suppresses every clean-range request
  a_r7_no_clean_wt: assert property (@(posedge clk) disable iff (!rstN)
    (mOpValid && wtR) |-> mOpKind != KIND_CLEAN_RANGE);

endmodule

// File: rtl/cache_range_seq.sv
module cache_range_seq
  import cache_range_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int MAX_CHUNK  = 1024,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdStart,
  input  logic [ADDR_W-1:0] cmdEnd,
  input  logic              wtOverride,
  output logic              mOpValid,
  output logic [1:0]        mOpKind,
  output logic [ADDR_W-1:0] mOpStart,
  output logic [ADDR_W-1:0] mOpEnd,
  input  logic              mOpDone,
  output logic              busy,
  output logic              barrier
);
  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);

  ctrlStrb_t strb;
  dpFlags_t  flags;

  cache_range_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdOp      (cmdOp),
    .wtOverride (wtOverride),
    .flags      (flags),
    .mOpDone    (mOpDone),
    .strb       (strb),
    .cmdReady   (cmdReady),
    .mOpValid   (mOpValid),
    .mOpKind    (mOpKind),
    .busy       (busy),
    .barrier    (barrier)
  );

  cache_range_seq_dp #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .MAX_CHUNK  (MAX_CHUNK),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cmdOp    (cmdOp),
    .cmdStart (cmdStart),
    .cmdEnd   (cmdEnd),
    .flags    (flags),
    .mOpStart (mOpStart),
    .mOpEnd   (mOpEnd)
  );

  // R2: range request spans at most MAX_CHUNK bytes, end not below start
  a_r2_chunk_size: assert property (@(posedge clk) disable iff (!rstN)
    (mOpValid && mOpKind != KIND_CI_LINE) |->
      (mOpEnd >= mOpStart) && ({1'b0, mOpEnd - mOpStart} < (ADDR_W+1)'(MAX_CHUNK)));

  // R3: range request stays in one page
  a_r3_same_page: assert property (@(posedge clk) disable iff (!rstN)
    mOpValid |-> (mOpStart[ADDR_W-1:PAGE_SHIFT] == mOpEnd[ADDR_W-1:PAGE_SHIFT]));

  // R8: request held until completion
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (mOpValid && !mOpDone) |=> mOpValid && $stable(mOpStart)
                               && $stable(mOpEnd) && $stable(mOpKind));

endmodule

// File: tb/cache_range_seq_tb_top.sv
module cache_range_seq_tb_top;
  localparam int AW = 10;
  localparam int LB = 32;
  localparam int MC = 128;
  localparam int PB = 256;
  localparam int LM = LB - 1;
  localparam int PM = PB - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic cmdReady;
  logic [1:0] cmdOp = 2'd0;
  logic [AW-1:0] cmdStart = '0, cmdEnd = '0;
  logic wtOverride = 1'b0;
  logic mOpValid;
  logic [1:0] mOpKind;
  logic [AW-1:0] mOpStart, mOpEnd;
  logic mOpDone = 1'b0;
  logic busy, barrier;

  always #10 clk = ~clk;

  cache_range_seq #(.ADDR_W(AW), .LINE_BYTES(LB), .MAX_CHUNK(MC), .PAGE_BYTES(PB)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdStart(cmdStart), .cmdEnd(cmdEnd), .wtOverride(wtOverride),
    .mOpValid(mOpValid), .mOpKind(mOpKind), .mOpStart(mOpStart), .mOpEnd(mOpEnd),
    .mOpDone(mOpDone), .busy(busy), .barrier(barrier));

  int checks = 0, fails = 0;
  int expS[64], expE[64], expK[64], expCnt;
  int gotS[64], gotE[64], gotK[64], gotCnt;
  int barrierCnt, gotAtBarrier, waitCnt, delaySel;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void addExp(input int k, input int s, input int e);
    if (expCnt < 64) begin
      expK[expCnt] = k; expS[expCnt] = s; expE[expCnt] = e;
    end
    expCnt++;
  endfunction

  function automatic int chunkBound(input int s, input int e);
    int b;
    b = e;
    if (s + MC < b) b = s + MC;
    if ((s | PM) + 1 < b) b = (s | PM) + 1;
    return b;
  endfunction

  // expected request stream built from R2..R8
  function automatic void buildExp(input int op, input int st, input int en, input bit wt);
    int s, e, b;
    expCnt = 0;
    s = st; e = en;
    if (op == 0) begin
      if ((s & LM) != 0) begin            // R4
        addExp(2, s & ~LM, s & ~LM);
        s = (s | LM) + 1;
      end
      if (s < e && (e & LM) != 0) begin   // R5
        addExp(2, e & ~LM, e & ~LM);
        e = e & ~LM;
      end
      while (s < e) begin
        b = chunkBound(s, e);
        addExp(0, s, b - LB);
        s = b;
      end
    end else begin
      s = s & ~LM;                        // R6
      e = (e + LM) & ~LM;
      while (s < e) begin
        b = chunkBound(s, e);
        if (op == 2) begin                // R8
          if (!wt) addExp(1, s, b - LB);
          addExp(0, s, b - LB);
        end else if (!wt) begin           // R7
          addExp(1, s, b - LB);
        end
        s = b;
      end
    end
  endfunction

  // downstream model: logs requests and returns completion after a delay
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (barrier) begin
        barrierCnt++;
        gotAtBarrier = gotCnt;
      end
      if (mOpDone) begin
        mOpDone = 1'b0;
        waitCnt = delaySel;
      end else if (mOpValid) begin
        if (waitCnt > 0) waitCnt--;
        else begin
          if (gotCnt < 64) begin
            gotS[gotCnt] = int'(mOpStart);
            gotE[gotCnt] = int'(mOpEnd);
            gotK[gotCnt] = int'(mOpKind);
          end
          gotCnt++;
          mOpDone = 1'b1;
        end
      end
    end
  end

  task automatic finish();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish();
  end

  task automatic runCmd(input int op, input int st, input int en, input bit wt);
    int bad;
    buildExp(op, st, en, wt);
    gotCnt = 0; barrierCnt = 0; gotAtBarrier = -1; waitCnt = delaySel;
    @(negedge clk);
    cmdOp = 2'(op); cmdStart = AW'(st); cmdEnd = AW'(en); wtOverride = wt;
    cmdValid = 1'b1;
    @(negedge clk); #1;
    check(busy && !cmdReady, "R10", "busy/not-ready after accept", {busy, cmdReady}, 2);
    // garbage while busy must not alter the command in flight (R10)
    cmdOp = 2'(op + 1); cmdStart = AW'(st + 77); cmdEnd = AW'(en + 301); wtOverride = !wt;
    while (barrierCnt == 0) begin
      @(negedge clk); #1;
    end
    cmdValid = 1'b0;
    check(gotCnt == expCnt, "R2", "request count", gotCnt, expCnt);
    bad = -1;
    for (int i = 0; i < expCnt && i < gotCnt && i < 64; i++)
      if (bad < 0 && (gotS[i] != expS[i] || gotE[i] != expE[i] || gotK[i] != expK[i]))
        bad = i;
    if (bad >= 0) begin
      if (op == 0)
        check(0, "R4", $sformatf("inv st=%0d en=%0d idx %0d start/kind", st, en, bad),
              gotS[bad] * 4 + gotK[bad], expS[bad] * 4 + expK[bad]);
      else
        check(0, op == 2 ? "R8" : "R6", $sformatf("op%0d wt%0d st=%0d en=%0d idx %0d end", op, wt, st, en, bad),
              gotE[bad], expE[bad]);
    end else
      check(1, "R3", "stream", 0, 0);
    check(gotAtBarrier == expCnt, "R9", "barrier after last request", gotAtBarrier, expCnt);
    @(negedge clk); #1;
    check(barrierCnt == 1 && !busy, "R9", "single barrier then idle", barrierCnt, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(cmdReady && !busy && !mOpValid && !barrier, "R1", "reset outputs",
          {cmdReady, busy, mOpValid, barrier}, 8);
    @(negedge clk); rstN = 1'b1;
    // directed corners: R5 tail only, R4 head passes end, R7 override clean
    delaySel = 0;
    runCmd(0, 64, 200, 0);
    runCmd(0, 70, 75, 0);
    runCmd(1, 3, 500, 1);
    runCmd(2, 250, 260, 1);
    runCmd(2, 0, 0, 0);
    for (int st = 0; st < 610; st += 19)
      for (int ln = 0; ln < 370; ln += 41)
        for (int op = 0; op < 3; op++)
          for (int wt = 0; wt < 2; wt++) begin
            delaySel = (st + ln + op) % 3;
            runCmd(op, st, st + ln, wt[0]);
          end
    finish();
  end
endmodule